// File: doc/BRIEF.md
# Tone Frequency Table Loader

This peripheral lets a processor fill, one word at a time, the table of frequency words that drives a bank of tone generators. Software writes a single 32-bit control register that holds a frequency value, the table slot it belongs in, and a strobe bit. Raising the strobe asks the block to store that word. The block writes the word into its table once, no matter how long the strobe stays high. It then waits for software to drop the strobe before it accepts another word.

The block counts the words stored since the last word aimed at slot 0. When the count reaches the table depth, it raises a "set complete" flag. One clock later it raises an enable that starts the tone generators. Writing slot 0 again starts a new set: the count restarts and both flags drop, so further sets can be loaded without a reset. A combinational read port exposes the table contents to the generators.

Software keeps the strobe high for about 480 ns, which is 96 cycles at 200 MHz. The block finishes each store within three cycles of the register write.

Top module: `freq_loader`

## Requirements
- R1: While reset is high, and on the first cycle after it, `buf_we`, `freq_ok` and `gen_we` are low. Reset also clears the word count.
- R2: The control word carries the frequency in bits 19:0, the slot number in bits 27:20 and the strobe in bit 31. Bits 30:28 have no effect on what is stored.
- R3: Take a bus write, sampled at clock edge k, that raises the strobe and names a slot below DEPTH. It produces exactly one `buf_we` pulse, high only between edges k+1 and k+2. The word is readable at `rd_data` after edge k+2.
- R4: Exactly one store happens per high period of the strobe. Bus writes that change data or slot while the strobe stays high store nothing. Storing is re-armed only after a bus write that clears the strobe.
- R5: A strobed word whose slot is DEPTH or above causes no `buf_we` pulse and is not counted toward the set.
- R6: `freq_ok` rises at edge k+2 of the strobed write that brings the count of stored words, since the last slot-0 word, to DEPTH. It stays low before that.
- R7: `gen_we` equals `freq_ok` delayed by one clock cycle.
- R8: A strobed word for slot 0 restarts the count at one. It clears `freq_ok` at edge k+1 and `gen_we` at edge k+2.
- R9: `rd_data` shows, combinationally, the last value stored at slot `rd_addr`. It shows zero for a slot of DEPTH or above.
- R10: Once set, `freq_ok` stays high through further non-slot-0 stores and strobe-clearing writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe of the processor register port |
| bus_wdata | input | 32 | Control word: strobe[31], spare[30:28], slot[27:20], frequency[19:0] |
| rd_addr | input | 8 | Table read slot |
| rd_data | output | 20 | Frequency stored at `rd_addr` |
| buf_we | output | 1 | One-cycle pulse marking each table store |
| freq_ok | output | 1 | Full set stored |
| gen_we | output | 1 | Generator start, one cycle after `freq_ok` |

## Verification
Measured from the edge k that samples a strobe-raising bus write:
- the store pulse is due between edges k+1 and k+2;
- the stored value and a rising `freq_ok` are due after k+2;
- `gen_we` follows at k+3;
- a slot-0 restart drops `freq_ok` after k+1 and `gen_we` after k+2.

The bench drives inputs on falling edges and samples the outputs at the falling edge after each of these edges. This places every observation exactly in its due cycle and never on an active edge. The table port is read one time step after `rd_addr` settles.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
    localparam int WORD_W   = 32;
    localparam int FREQ_W   = 20;
    localparam int SLOT_W   = 8;
    localparam int SPARE_W  = WORD_W - 1 - SLOT_W - FREQ_W;

    // Bit layout of the control register (R2): strobe at the top,
    // slot above the frequency field, frequency in the low bits.
    typedef struct packed {
        logic               strobe;
        logic [SPARE_W-1:0] spare;
        logic [SLOT_W-1:0]  slot;
        logic [FREQ_W-1:0]  freq;
    } ctrl_word_t;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } seq_state_t;

    function automatic logic slot_valid(input logic [SLOT_W-1:0] slot, input int depth);
        return int'(slot) < depth;
    endfunction
endpackage

// File: rtl/fwl_ctrl_reg.sv
module fwl_ctrl_reg
    import fwl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                strobe,
    output logic [SLOT_W-1:0]   slot,
    output logic [FREQ_W-1:0]   freq
);
    ctrl_word_t word_q;
    logic       unused_spare;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= ctrl_word_t'(wr_data);
        end
    end

    assign strobe       = word_q.strobe;
    assign slot         = word_q.slot;
    assign freq         = word_q.freq;
    assign unused_spare = ^word_q.spare;

    // The register only changes on a bus write (R10 relies on this)
    assert_reg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(word_q));
endmodule

// File: rtl/fwl_seq.sv
module fwl_seq
    import fwl_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [FREQ_W-1:0]   freq,
    output logic                st_we,
    output logic [SLOT_W-1:0]   st_slot,
    output logic [FREQ_W-1:0]   st_freq,
    output logic                set_ok,
    output logic                gen_start
);
    seq_state_t         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               we_q;
    logic               ok_q;
    logic               gen_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [FREQ_W-1:0]  freq_q;
    logic               accept;
    logic               full_now;

    assign accept   = (state_q == ST_ARMED) && strobe && slot_valid(slot, DEPTH);
    assign full_now = (cnt_q == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
            we_q    <= 1'b0;
            ok_q    <= 1'b0;
            gen_q   <= 1'b0;
            slot_q  <= '0;
            freq_q  <= '0;
        end else begin
            we_q  <= 1'b0;
            gen_q <= ok_q;
            if (we_q && full_now) begin
                ok_q <= 1'b1;
            end
            unique case (state_q)
                ST_ARMED: begin
                    if (strobe) begin
                        state_q <= ST_HELD;
                    end
                    if (accept) begin
                        we_q   <= 1'b1;
                        slot_q <= slot;
                        freq_q <= freq;
                        if (slot == '0) begin
                            cnt_q <= CNT_W'(1);
                            ok_q  <= 1'b0;
                        end else if (!full_now) begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                end
                ST_HELD: begin
                    if (!strobe) begin
                        state_q <= ST_ARMED;
                    end
                end
                default: state_q <= ST_ARMED;
            endcase
        end
    end

    assign st_we     = we_q;
    assign st_slot   = slot_q;
    assign st_freq   = freq_q;
    assign set_ok    = ok_q;
    assign gen_start = gen_q;

    assert_store_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        we_q |=> !we_q);
    assert_store_needs_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        we_q |-> $past(strobe));
    assert_one_per_high_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HELD && strobe) |=> !we_q);
    assert_slot_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        we_q |-> (int'(slot_q) < DEPTH));
    assert_ok_after_store_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_q) |-> $past(we_q));
    assert_gen_follows_ok_R7: assert property (@(posedge clk) disable iff (rst)
        gen_q == $past(ok_q));
endmodule

// File: rtl/fwl_table.sv
module fwl_table
    import fwl_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SLOT_W-1:0]   wr_slot,
    input  logic [FREQ_W-1:0]   wr_freq,
    input  logic [SLOT_W-1:0]   rd_slot,
    output logic [FREQ_W-1:0]   rd_freq
);
    logic [FREQ_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    assign wr_idx = wr_slot[IDX_W-1:0];
    assign rd_idx = rd_slot[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_freq;
        end
    end

    always_comb begin
        if (slot_valid(rd_slot, DEPTH)) begin
            rd_freq = mem[rd_idx];
        end else begin
            rd_freq = '0;
        end
    end

    assert_store_lands_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_freq)));
endmodule

// File: rtl/freq_loader.sv
module freq_loader
    import fwl_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic [SLOT_W-1:0]   rd_addr,
    output logic [FREQ_W-1:0]   rd_data,
    output logic                buf_we,
    output logic                freq_ok,
    output logic                gen_we
);
    logic               c_strobe;
    logic [SLOT_W-1:0]  c_slot;
    logic [FREQ_W-1:0]  c_freq;
    logic               s_we;
    logic [SLOT_W-1:0]  s_slot;
    logic [FREQ_W-1:0]  s_freq;

    fwl_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_we),
        .wr_data (bus_wdata),
        .strobe  (c_strobe),
        .slot    (c_slot),
        .freq    (c_freq)
    );

    fwl_seq #(.DEPTH(DEPTH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .strobe    (c_strobe),
        .slot      (c_slot),
        .freq      (c_freq),
        .st_we     (s_we),
        .st_slot   (s_slot),
        .st_freq   (s_freq),
        .set_ok    (freq_ok),
        .gen_start (gen_we)
    );

    fwl_table #(.DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (s_we),
        .wr_slot (s_slot),
        .wr_freq (s_freq),
        .rd_slot (rd_addr),
        .rd_freq (rd_data)
    );

    assign buf_we = s_we;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!buf_we && !freq_ok && !gen_we));
endmodule

// File: tb/tb_freq_loader.sv
module tb_freq_loader;
    localparam int DEPTH = 128;
    localparam int HOLD  = 90;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [7:0]  rd_addr = '0;
    logic [19:0] rd_data;
    logic        buf_we;
    logic        freq_ok;
    logic        gen_we;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic ok_n2, ok_n3, gwe_n3, gwe_n4;

    always #2.5 clk = ~clk;

    freq_loader #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data), .buf_we(buf_we),
        .freq_ok(freq_ok), .gen_we(gen_we)
    );

    // bit 32: store pulse expected; bits 31:0: control word with strobe cleared
    localparam logic [32:0] VEC [6] = '{
        {1'b1, 1'b0, 3'b000, 8'd0,   20'h001FE},
        {1'b1, 1'b0, 3'b101, 8'd1,   20'h0038E},
        {1'b1, 1'b0, 3'b111, 8'd127, 20'h0086E},
        {1'b1, 1'b0, 3'b010, 8'd64,  20'hFFFFF},
        {1'b0, 1'b0, 3'b000, 8'd200, 20'h12345},
        {1'b1, 1'b0, 3'b011, 8'd2,   20'h00000}
    };

    task automatic chk(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [19:0] d, input logic [2:0] j, input bit pulse);
        @(negedge clk); bus_we = 1'b1; bus_wdata = {1'b1, j, a, d};
        @(negedge clk); bus_we = 1'b0;
        chk(buf_we == 1'b0, "R3 no pulse at k", 32'(buf_we), 0);
        @(negedge clk);
        chk(buf_we == pulse, pulse ? "R3 pulse at k+1" : "R5 out-of-range store", 32'(buf_we), 32'(pulse));
        ok_n2 = freq_ok;
        @(negedge clk);
        chk(buf_we == 1'b0, "R3 single-cycle pulse", 32'(buf_we), 0);
        ok_n3 = freq_ok; gwe_n3 = gen_we;
        @(negedge clk);
        gwe_n4 = gen_we;
        repeat (HOLD) @(negedge clk);
        @(negedge clk); bus_we = 1'b1; bus_wdata = {1'b0, j, a, d};
        @(negedge clk); bus_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [19:0] exp, input string req);
        rd_addr = a;
        #1;
        chk(rd_data == exp, req, 32'(rd_data), 32'(exp));
    endtask

    function automatic logic [19:0] set_val(input int i);
        if (i == DEPTH - 1) return 20'h0086E;
        return 20'(20'h001FE + i * 20'h190);
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        chk({buf_we, freq_ok, gen_we} == 3'b000, "R1 outputs in reset", 32'({buf_we, freq_ok, gen_we}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({buf_we, freq_ok, gen_we} == 3'b000, "R1 outputs after reset", 32'({buf_we, freq_ok, gen_we}), 0);

        // Vector table walk: R2 field layout, R3 timing, R5 range
        foreach (VEC[v]) begin
            put(VEC[v][27:20], VEC[v][19:0], VEC[v][30:28], VEC[v][32]);
            if (VEC[v][32]) rd_chk(VEC[v][27:20], VEC[v][19:0], "R2 stored frequency field");
        end
        rd_chk(8'd200, 20'h0, "R9 out-of-range read is zero");
        chk(freq_ok == 1'b0, "R6 partial set not ok", 32'(freq_ok), 0);

        // Full set with an out-of-range word in the middle
        for (int i = 0; i < DEPTH; i++) begin
            if (i == 64) put(8'd250, 20'hABCDE, 3'b000, 1'b0);
            put(8'(i), set_val(i), 3'b000, 1'b1);
            if (i == 0) chk(ok_n2 == 1'b0, "R8 restart keeps ok low", 32'(ok_n2), 0);
            if (i == DEPTH - 2) chk(freq_ok == 1'b0, "R6 ok low before last word", 32'(freq_ok), 0);
        end
        chk(ok_n2 == 1'b0, "R6 ok low at k+1 of last word", 32'(ok_n2), 0);
        chk(ok_n3 == 1'b1, "R6 ok high at k+2 of last word", 32'(ok_n3), 1);
        chk(gwe_n3 == 1'b0, "R7 gen_we low while ok just rose", 32'(gwe_n3), 0);
        chk(gwe_n4 == 1'b1, "R7 gen_we one cycle after ok", 32'(gwe_n4), 1);
        for (int i = 0; i < DEPTH; i++) rd_chk(8'(i), set_val(i), "R9 table readback");

        // R4: a second write while strobe stays high stores nothing
        @(negedge clk); bus_we = 1'b1; bus_wdata = {1'b1, 3'b000, 8'd5, 20'hAAAAA};
        @(negedge clk); bus_we = 1'b0;
        repeat (4) @(negedge clk);
        @(negedge clk); bus_we = 1'b1; bus_wdata = {1'b1, 3'b000, 8'd5, 20'h55555};
        @(negedge clk); bus_we = 1'b0;
        seen = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (buf_we) seen = 1'b1;
        end
        chk(seen == 1'b0, "R4 no store while strobe held", 32'(seen), 0);
        rd_chk(8'd5, 20'hAAAAA, "R4 first word kept");
        @(negedge clk); bus_we = 1'b1; bus_wdata = {1'b0, 3'b000, 8'd5, 20'h55555};
        @(negedge clk); bus_we = 1'b0;
        put(8'd5, 20'h55555, 3'b000, 1'b1);
        rd_chk(8'd5, 20'h55555, "R4 re-armed after strobe low");
        chk(freq_ok == 1'b1, "R10 ok stays set", 32'(freq_ok), 1);
        chk(gen_we == 1'b1, "R10 gen_we stays set", 32'(gen_we), 1);

        // R8: slot-0 word restarts the set
        put(8'd0, 20'h00777, 3'b000, 1'b1);
        chk(ok_n2 == 1'b0, "R8 ok cleared at k+1", 32'(ok_n2), 0);
        chk(gwe_n3 == 1'b0, "R8 gen_we cleared at k+2", 32'(gwe_n3), 0);
        chk(freq_ok == 1'b0, "R8 ok stays low", 32'(freq_ok), 0);

        // R1: reset during a partial set
        put(8'd1, 20'h00123, 3'b000, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk({buf_we, freq_ok, gen_we} == 3'b000, "R1 mid-run reset", 32'({buf_we, freq_ok, gen_we}), 0);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
    end
endmodule